// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a processor core and a 32-bit data memory that stores its words most-significant byte first (big-endian). For each memory request it adds the base register to the sign-extended 16-bit displacement. It then issues the access at the word-aligned address. For stores it also drives the byte enables and places the write data in the correct lanes.

For loads it remembers which kind of load is pending and the low two address bits. It also keeps the previous contents of the destination register. When the memory returns the aligned word, the unit forms the register value. That value may be a sign- or zero-extended byte or halfword, a whole word, or a left or right partial-word merge. A merge keeps part of the old register contents, as the byte offset selects.

A misaligned flag is raised with the request when a halfword or word access has an address it cannot serve aligned. The access is still issued. The core decides whether to trap.

Top module: `mem_lane_unit`

## Requirements
- R1: One clock after a request with a memory opcode, `mem_valid` is 1 and `mem_addr` equals base plus the sign-extended 16-bit offset with bits 1:0 forced to zero; the byte offset k is the effective address modulo 4.
- R2: Load opcodes (32, 33, 34, 35, 36, 37, 38, 48) issue a read: `mem_we`=0 and `mem_be`=4'b0000. `ld_valid` pulses and `ld_result` is updated one clock after `rsp_valid` is sampled high.
- R3: Byte order is big-endian: offset k selects bits 31-8k down to 24-8k. Opcode 32 sign-extends the selected byte and opcode 36 zero-extends it.
- R4: Opcode 33 sign-extends and opcode 37 zero-extends a halfword: bits 31:16 when k is 0 or 1, bits 15:0 when k is 2 or 3.
- R5: Opcodes 35 and 48 return the whole memory word unchanged.
- R6: Opcode 34 returns the memory word shifted left by 8k bits. The low 8k bits of the old register value are ORed in.
- R7: Opcode 38 returns the old register value unchanged when k=0. Otherwise it returns the memory word shifted right by 32-8k bits, ORed with the old register value's upper 32-8k bits.
- R8: Store opcodes 40, 41 and 43 set `mem_we`=1. Opcode 40 enables lane 4'b1000>>k and puts rt[7:0] in every byte. Opcode 41 enables 4'b1100 when k<2 and 4'b0011 otherwise, and puts rt[15:0] in both halves. Opcode 43 enables 4'b1111 and writes rt as is.
- R9: Opcode 56 behaves exactly as opcode 43.
- R10: `misaligned` is 1 with the access for opcodes 33, 37 and 41 when k is odd. It is also 1 for opcodes 35, 43, 48 and 56 when k is not 0. It is 0 for every other access.
- R11: A request whose opcode is not listed above issues no access. A later response is still merged using the most recent load request.
- R12: During and right after reset, `mem_valid`, `mem_we`, `misaligned` and `ld_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Primary opcode of the instruction |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_rt | input | 32 | rt value: store data, or old destination value for merges |
| mem_valid | output | 1 | Memory access issued |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-positioned write data |
| misaligned | output | 1 | Access address not naturally aligned |
| rsp_valid | input | 1 | Memory read word present |
| rsp_rdata | input | 32 | Aligned word returned by memory |
| ld_valid | output | 1 | Load result present |
| ld_result | output | 32 | Value to write to the destination register |

## Verification
Every cycle, the assertions check that issued addresses are word-aligned and that reads carry no byte enables. They also check that store enables have one of the legal shapes, that writes and the misaligned flag occur only with an issued access, and that load results appear only one cycle after a response. Only the bench scenarios can show that the enabled lane and the data placed in it match the byte offset. The same holds for the extension of bytes and halfwords and for how much of the old register each partial-word merge keeps at each offset. The bench scenarios also show that a non-memory opcode leaves the pending load context alone.

// File: rtl/mem_lane_pkg.sv
package mem_lane_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int OFF_W   = $clog2(LANES);

    typedef enum logic [2:0] {
        LK_BYTE_S,
        LK_BYTE_U,
        LK_HALF_S,
        LK_HALF_U,
        LK_WORD,
        LK_LEFT,
        LK_RIGHT
    } ld_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE,
        SZ_HALF,
        SZ_WORD,
        SZ_PART
    } acc_size_e;

endpackage

// File: rtl/mem_op_decode.sv
module mem_op_decode
    import mem_lane_pkg::*;
(
    input  logic [5:0] op,
    output logic       is_load,
    output logic       is_store,
    output ld_kind_e   kind,
    output acc_size_e  size
);

    always_comb begin
        is_load  = 1'b0;
        is_store = 1'b0;
        kind     = LK_WORD;
        size     = SZ_WORD;
        case (op)
            6'd32: begin is_load  = 1'b1; kind = LK_BYTE_S; size = SZ_BYTE; end
            6'd33: begin is_load  = 1'b1; kind = LK_HALF_S; size = SZ_HALF; end
            6'd34: begin is_load  = 1'b1; kind = LK_LEFT;   size = SZ_PART; end
            6'd35: begin is_load  = 1'b1; kind = LK_WORD;   size = SZ_WORD; end
            6'd36: begin is_load  = 1'b1; kind = LK_BYTE_U; size = SZ_BYTE; end
            6'd37: begin is_load  = 1'b1; kind = LK_HALF_U; size = SZ_HALF; end
            6'd38: begin is_load  = 1'b1; kind = LK_RIGHT;  size = SZ_PART; end
            6'd48: begin is_load  = 1'b1; kind = LK_WORD;   size = SZ_WORD; end
            6'd40: begin is_store = 1'b1; size = SZ_BYTE; end
            6'd41: begin is_store = 1'b1; size = SZ_HALF; end
            6'd43: begin is_store = 1'b1; size = SZ_WORD; end
            6'd56: begin is_store = 1'b1; size = SZ_WORD; end
            default: ;
        endcase
    end

endmodule

// File: rtl/mem_addr_gen.sv
module mem_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IMM_W-1:0]  offset,
    output logic [ADDR_W-1:0] eff_addr
);

    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] offset_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign offset_ext = {{EXT_W{offset[IMM_W-1]}}, offset};
        end else begin : g_trunc
            assign offset_ext = offset[ADDR_W-1:0];
        end
    endgenerate

    assign eff_addr = base + offset_ext;

endmodule

// File: rtl/mem_store_lanes.sv
module mem_store_lanes
    import mem_lane_pkg::*;
(
    input  acc_size_e          size,
    input  logic [OFF_W-1:0]   k,
    input  logic [DATA_W-1:0]  rt,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  wdata
);

    // Lane i holds byte offset i, i.e. bits DATA_W-1-8i down to DATA_W-8-8i.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(i);
        localparam int HI = DATA_W - 1 - 8 * i;
        logic hit;
        always_comb begin
            case (size)
                SZ_BYTE: hit = (k == LANE_OFF);
                SZ_HALF: hit = (k[OFF_W-1] == LANE_OFF[OFF_W-1]);
                default: hit = 1'b1;
            endcase
        end
        assign be[LANES-1-i] = hit;
        always_comb begin
            case (size)
                SZ_BYTE: wdata[HI -: 8] = rt[7:0];
                SZ_HALF: wdata[HI -: 8] = LANE_OFF[0] ? rt[7:0] : rt[15:8];
                default: wdata[HI -: 8] = rt[HI -: 8];
            endcase
        end
    end

endmodule

// File: rtl/mem_load_merge.sv
module mem_load_merge
    import mem_lane_pkg::*;
(
    input  ld_kind_e           kind,
    input  logic [OFF_W-1:0]   k,
    input  logic [DATA_W-1:0]  word,
    input  logic [DATA_W-1:0]  rt_old,
    output logic [DATA_W-1:0]  result
);

    localparam int SH_W = $clog2(DATA_W) + 1;

    logic [7:0]        byte_sel;
    logic [15:0]       half_sel;
    logic [SH_W-1:0]   sh_bits;
    logic [SH_W-1:0]   sh_rest;
    logic [DATA_W-1:0] ones_up;

    always_comb begin
        byte_sel = 8'h00;
        for (int i = 0; i < LANES; i++) begin
            if (k == OFF_W'(i)) byte_sel = word[DATA_W-1-8*i -: 8];
        end
        half_sel = k[OFF_W-1] ? word[15:0] : word[31:16];
        sh_bits  = SH_W'({k, 3'b000});
        sh_rest  = SH_W'(DATA_W) - sh_bits;
        ones_up  = {DATA_W{1'b1}} << sh_bits;

        case (kind)
            LK_BYTE_S: result = {{(DATA_W-8){byte_sel[7]}}, byte_sel};
            LK_BYTE_U: result = {{(DATA_W-8){1'b0}}, byte_sel};
            LK_HALF_S: result = {{(DATA_W-16){half_sel[15]}}, half_sel};
            LK_HALF_U: result = {{(DATA_W-16){1'b0}}, half_sel};
            LK_LEFT:   result = (word << sh_bits) | (rt_old & ~ones_up);
            LK_RIGHT:  result = (k == '0) ? rt_old
                              : ((word >> sh_rest) | (rt_old & ones_up));
            default:   result = word;
        endcase
    end

endmodule

// File: rtl/mem_lane_unit.sv
module mem_lane_unit
    import mem_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [5:0]        req_op,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [IMM_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] req_rt,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              misaligned,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_result
);

    typedef struct packed {
        logic              mv;
        logic              we;
        logic [LANES-1:0]  be;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wd;
        logic              mis;
        ld_kind_e          kind;
        logic [OFF_W-1:0]  k;
        logic [DATA_W-1:0] rt;
        logic              lv;
        logic [DATA_W-1:0] res;
    } state_t;

    state_t st_d, st_q;

    logic              dec_load, dec_store;
    ld_kind_e          dec_kind;
    acc_size_e         dec_size;
    logic [ADDR_W-1:0] ea;
    logic [OFF_W-1:0]  ea_k;
    logic [LANES-1:0]  st_be;
    logic [DATA_W-1:0] st_wd;
    logic [DATA_W-1:0] merged;

    mem_op_decode u_dec (
        .op       (req_op),
        .is_load  (dec_load),
        .is_store (dec_store),
        .kind     (dec_kind),
        .size     (dec_size)
    );

    mem_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
        .base     (req_base),
        .offset   (req_offset),
        .eff_addr (ea)
    );

    assign ea_k = ea[OFF_W-1:0];

    mem_store_lanes u_st (
        .size  (dec_size),
        .k     (ea_k),
        .rt    (req_rt),
        .be    (st_be),
        .wdata (st_wd)
    );

    mem_load_merge u_ld (
        .kind   (st_q.kind),
        .k      (st_q.k),
        .word   (rsp_rdata),
        .rt_old (st_q.rt),
        .result (merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.mv  = 1'b0;
        st_d.we  = 1'b0;
        st_d.mis = 1'b0;
        st_d.lv  = rsp_valid;
        if (rsp_valid) st_d.res = merged;
        if (req_valid && (dec_load || dec_store)) begin
            st_d.mv   = 1'b1;
            st_d.we   = dec_store;
            st_d.addr = {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            st_d.be   = dec_store ? st_be : '0;
            st_d.wd   = dec_store ? st_wd : '0;
            case (dec_size)
                SZ_HALF: st_d.mis = ea_k[0];
                SZ_WORD: st_d.mis = (ea_k != '0);
                default: st_d.mis = 1'b0;
            endcase
        end
        if (req_valid && dec_load) begin
            st_d.kind = dec_kind;
            st_d.k    = ea_k;
            st_d.rt   = req_rt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= LK_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_valid  = st_q.mv;
    assign mem_we     = st_q.we;
    assign mem_addr   = st_q.addr;
    assign mem_be     = st_q.be;
    assign mem_wdata  = st_q.wd;
    assign misaligned = st_q.mis;
    assign ld_valid   = st_q.lv;
    assign ld_result  = st_q.res;

    assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

    assert_read_no_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we) |-> (mem_be == '0));

    assert_result_after_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(rsp_valid));

    assert_store_enable_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> ($onehot0(mem_be) && mem_be != '0
            || mem_be == 4'b1100 || mem_be == 4'b0011 || mem_be == 4'b1111));

    assert_flag_with_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> (mem_valid && mem_be != 4'b1000 && mem_be != 4'b0100
            && mem_be != 4'b0010 && mem_be != 4'b0001));

    assert_write_needs_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |-> !mem_we);

endmodule

// File: tb/sim_mem_lane_unit.sv
`timescale 1ns/1ps
module sim_mem_lane_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_op = '0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_rt = '0;
    logic        mem_valid, mem_we, misaligned, ld_valid;
    logic [31:0] mem_addr, mem_wdata, ld_result;
    logic [3:0]  mem_be;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mem_lane_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_offset(req_offset), .req_rt(req_rt),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .misaligned(misaligned),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ld_valid(ld_valid), .ld_result(ld_result)
    );

    localparam logic [31:0] WA = 32'h8A7B_C6D5;
    localparam logic [31:0] WB = 32'h1234_F678;
    localparam logic [31:0] RT = 32'hA1B2_C3D4;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic send_req(logic [5:0] op, logic [31:0] base, logic [15:0] off, logic [31:0] rt);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_base = base; req_offset = off; req_rt = rt;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_rsp(logic [31:0] w);
        rsp_valid = 1'b1; rsp_rdata = w;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    function automatic logic [7:0] pick_byte(logic [31:0] w, int k);
        case (k)
            0: return w[31:24];
            1: return w[23:16];
            2: return w[15:8];
            default: return w[7:0];
        endcase
    endfunction

    task automatic do_load(string req, logic [5:0] op, int k, logic [31:0] w, logic [31:0] exp);
        send_req(op, 32'h0000_2000, 16'(k), RT);
        chk({req, " mem_valid"}, {31'b0, mem_valid}, 32'd1);
        chk({req, " read we/be"}, {27'b0, mem_we, mem_be}, 32'd0);
        chk({req, " addr"}, mem_addr, 32'h0000_2000);
        send_rsp(w);
        chk({req, " ld_valid"}, {31'b0, ld_valid}, 32'd1);
        chk({req, " result"}, ld_result, exp);
    endtask

    task automatic do_store(string req, logic [5:0] op, int k, logic [3:0] be, logic [31:0] wd);
        send_req(op, 32'h0000_3000, 16'(k), RT);
        chk({req, " mem_valid/we"}, {30'b0, mem_valid, mem_we}, 32'd3);
        chk({req, " be"}, {28'b0, mem_be}, {28'b0, be});
        chk({req, " wdata"}, mem_wdata, wd);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 reset outputs", {28'b0, mem_valid, mem_we, misaligned, ld_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 after reset", {28'b0, mem_valid, mem_we, misaligned, ld_valid}, 32'd0);
    endtask

    task automatic t_addr;
        send_req(6'd35, 32'h0000_1000, 16'hFFF6, RT);
        chk("R1 negative offset addr", mem_addr, 32'h0000_0FF4);
        send_req(6'd35, 32'h7FFF_FFFC, 16'h0007, RT);
        chk("R1 positive offset addr", mem_addr, 32'h8000_0000);
        @(negedge clk);
        chk("R1 valid drops", {31'b0, mem_valid}, 32'd0);
    endtask

    task automatic t_bytes;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] b = pick_byte(WA, k);
            do_load("R3 signed byte", 6'd32, k, WA, {{24{b[7]}}, b});
            do_load("R3 unsigned byte", 6'd36, k, WA, {24'h0, b});
        end
    endtask

    task automatic t_halves;
        do_load("R4 signed half k0", 6'd33, 0, WA, 32'hFFFF_8A7B);
        do_load("R4 signed half k2", 6'd33, 2, WA, 32'hFFFF_C6D5);
        do_load("R4 signed half positive", 6'd33, 0, WB, 32'h0000_1234);
        do_load("R4 unsigned half k2", 6'd37, 2, WA, 32'h0000_C6D5);
    endtask

    task automatic t_words;
        do_load("R5 word", 6'd35, 0, WA, WA);
        do_load("R5 linked word", 6'd48, 0, WB, WB);
    endtask

    task automatic t_left;
        do_load("R6 left k0", 6'd34, 0, WA, 32'h8A7B_C6D5);
        do_load("R6 left k1", 6'd34, 1, WA, 32'h7BC6_D5D4);
        do_load("R6 left k2", 6'd34, 2, WA, 32'hC6D5_C3D4);
        do_load("R6 left k3", 6'd34, 3, WA, 32'hD5B2_C3D4);
    endtask

    task automatic t_right;
        do_load("R7 right k0", 6'd38, 0, WA, RT);
        do_load("R7 right k1", 6'd38, 1, WA, 32'hA1B2_C38A);
        do_load("R7 right k2", 6'd38, 2, WA, 32'hA1B2_8A7B);
        do_load("R7 right k3", 6'd38, 3, WA, 32'hA18A_7BC6);
    endtask

    task automatic t_stores;
        do_store("R8 byte k0", 6'd40, 0, 4'b1000, 32'hD4D4_D4D4);
        do_store("R8 byte k1", 6'd40, 1, 4'b0100, 32'hD4D4_D4D4);
        do_store("R8 byte k2", 6'd40, 2, 4'b0010, 32'hD4D4_D4D4);
        do_store("R8 byte k3", 6'd40, 3, 4'b0001, 32'hD4D4_D4D4);
        do_store("R8 half k0", 6'd41, 0, 4'b1100, 32'hC3D4_C3D4);
        do_store("R8 half k2", 6'd41, 2, 4'b0011, 32'hC3D4_C3D4);
        do_store("R8 word", 6'd43, 0, 4'b1111, RT);
        do_store("R9 conditional word", 6'd56, 0, 4'b1111, RT);
        chk("R8 store addr", mem_addr, 32'h0000_3000);
    endtask

    task automatic t_misalign;
        send_req(6'd33, 32'h0, 16'd1, RT);
        chk("R10 half odd", {31'b0, misaligned}, 32'd1);
        send_req(6'd37, 32'h0, 16'd2, RT);
        chk("R10 half even", {31'b0, misaligned}, 32'd0);
        send_req(6'd35, 32'h0, 16'd2, RT);
        chk("R10 word k2", {31'b0, misaligned}, 32'd1);
        send_req(6'd56, 32'h0, 16'd3, RT);
        chk("R10 cond store k3", {31'b0, misaligned}, 32'd1);
        send_req(6'd41, 32'h0, 16'd3, RT);
        chk("R10 half store odd", {31'b0, misaligned}, 32'd1);
        send_req(6'd32, 32'h0, 16'd3, RT);
        chk("R10 byte never", {31'b0, misaligned}, 32'd0);
        send_req(6'd34, 32'h0, 16'd1, RT);
        chk("R10 left merge never", {31'b0, misaligned}, 32'd0);
    endtask

    task automatic t_nonmem;
        send_req(6'd38, 32'h0000_4000, 16'd2, RT);
        send_req(6'd15, 32'h0000_5000, 16'd1, 32'h0);
        chk("R11 no access", {30'b0, mem_valid, mem_we}, 32'd0);
        send_req(6'd39, 32'h0000_5000, 16'd3, 32'h0);
        chk("R11 no access op39", {31'b0, mem_valid}, 32'd0);
        send_rsp(WA);
        chk("R11 context kept", ld_result, 32'hA1B2_8A7B);
    endtask

    initial begin
        t_reset();
        t_addr();
        t_bytes();
        t_halves();
        t_words();
        t_left();
        t_right();
        t_stores();
        t_misalign();
        t_nonmem();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule